// File: doc/BRIEF.md
# Recursive Sinusoid Oscillator

This block produces a sampled sine wave without a lookup table or a phase accumulator. It runs a second-order recursion: each new sample is the previous sample scaled by twice the cosine of the step angle, minus the sample before that. A single impulse enters the recursion once, scaled by the sine of the step angle. Software supplies the two coefficients. After a start pulse, each sample-enable strobe advances the recursion by one step and produces one signed sample.

All arithmetic is fixed point. Samples are Q15 (`DATA_W` = 16). The sine coefficient is Q15. The doubled-cosine coefficient is Q14, so values up to almost 2.0 fit. Every result is rounded and clipped to 16 bits before it is stored back as history. The recursion has feedback, so rounding error builds up over long runs. A new start pulse clears the history and reissues the impulse, which resynchronises the oscillator.

Top module: `impulse_resonator`

## Requirements
- R1: After reset, `sample_out` is 0 and `sample_valid` is 0. Reset clears the history and leaves no impulse pending.
- R2: `start` clears both stored outputs and the stored input, and arms the impulse. If `start` and `sample_en` are high in the same cycle, the start takes effect and no sample is produced.
- R3: The impulse value is +32767 (0x7FFF, the largest Q15 value). It enters on the first strobe after a start and is used as the delayed input on the second strobe only. The first sample after a start is therefore 0.
- R4: On each strobe the next sample is computed as y = cA·y1 + cB·x1 − y2. Here cA (`coef_a`) is signed Q14, cB (`coef_b`) is signed Q15, y1 and y2 are the last two samples and x1 is the delayed input. The sum is formed exactly at 2^-30 scale.
- R5: The exact sum is rounded half upward: add 2^14 at 2^-30 scale, then shift right arithmetically by 15.
- R6: A rounded result above 32767 becomes 32767, and one below −32768 becomes −32768. The clipped value is what is stored as history.
- R7: `sample_valid` is high for exactly one cycle, in the cycle after a strobe that was not overridden by a start. `sample_out` changes only in that cycle and otherwise holds its value.
- R8: A start issued in the middle of a sequence makes the following samples repeat the sequence from its beginning.
- R9: Strobes after reset with no start produce samples of value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the history and arms the impulse |
| sample_en | input | 1 | Advances the recursion by one sample |
| coef_a | input | 16 | Doubled cosine of the step angle, signed Q14 |
| coef_b | input | 16 | Sine of the step angle, signed Q15 |
| sample_out | output | 16 | Latest sample, signed Q15 |
| sample_valid | output | 1 | Pulses when `sample_out` is updated |

## Verification
The recursion is run with several coefficient pairs against a bit-exact model:
- A quarter-turn step (cA = 0) gives a period-four pattern. It isolates the delayed-impulse path and the y2 subtraction.
- A general step angle exercises the rounding on every sample of a long run.
- Coefficients near +2.0 and near −2.0 drive the output into the positive and the negative clip.
- Strobes with no start, a start during a run, a start that coincides with a strobe, and idle gaps between strobes cover resynchronisation and the hold behaviour.

// File: rtl/osc_pkg.sv
package osc_pkg;

   // How the wide sum is reduced back to sample precision
   typedef enum logic {
      RND_TRUNC   = 1'b0,
      RND_NEAREST = 1'b1
   } rnd_mode_e;

endpackage

// File: rtl/osc_history.sv
module osc_history #(
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     advance,
   input  logic signed [DATA_W-1:0] y_new,
   output logic signed [DATA_W-1:0] y1,
   output logic signed [DATA_W-1:0] y2,
   output logic signed [DATA_W-1:0] x1,
   output logic                     pending
);
   localparam logic signed [DATA_W-1:0] IMPULSE = {1'b0, {(DATA_W-1){1'b1}}};

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("osc_history: DATA_W must be at least 4");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y1      <= '0;
         y2      <= '0;
         x1      <= '0;
         pending <= 1'b0;
      end else if (clear) begin
         y1      <= '0;
         y2      <= '0;
         x1      <= '0;
         pending <= 1'b1;
      end else if (advance) begin
         y2      <= y1;
         y1      <= y_new;
         x1      <= pending ? IMPULSE : '0;
         pending <= 1'b0;
      end
   end

   // The impulse term may be used by one step only
   AST_IMPULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && x1 != '0) |=> (x1 == '0)); // R3

endmodule

// File: rtl/osc_mac.sv
module osc_mac #(
   parameter int                  DATA_W = 16,
   parameter int                  A_FRAC = 14,
   parameter osc_pkg::rnd_mode_e  RND    = osc_pkg::RND_NEAREST
) (
   input  logic signed [DATA_W-1:0] coef_a,
   input  logic signed [DATA_W-1:0] coef_b,
   input  logic signed [DATA_W-1:0] y1,
   input  logic signed [DATA_W-1:0] y2,
   input  logic signed [DATA_W-1:0] x1,
   output logic signed [DATA_W-1:0] y_next
);
   localparam int FRAC    = DATA_W - 1;
   localparam int A_SHIFT = FRAC - A_FRAC;
   localparam int PROD_W  = 2 * DATA_W;
   localparam int ACC_W   = PROD_W + A_SHIFT + 2;

   localparam logic signed [ACC_W-1:0] SAT_HI =
      $signed({{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
   localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;
   localparam logic signed [ACC_W-1:0] HALF   =
      $signed({{(ACC_W-1){1'b0}}, 1'b1}) <<< (FRAC - 1);

   generate
      if (A_FRAC > FRAC || A_FRAC < FRAC - 2) begin : g_bad_frac
         $error("osc_mac: A_FRAC must lie between DATA_W-3 and DATA_W-1");
      end
   endgenerate

   logic signed [PROD_W-1:0] prod_a;
   logic signed [PROD_W-1:0] prod_b;
   logic signed [ACC_W-1:0]  term_a;
   logic signed [ACC_W-1:0]  term_b;
   logic signed [ACC_W-1:0]  term_y2;
   logic signed [ACC_W-1:0]  sum;
   logic signed [ACC_W-1:0]  reduced;

   // Two multiplies, everything aligned to 2^-(2*FRAC)
   always_comb begin
      prod_a  = coef_a * y1;
      prod_b  = coef_b * x1;
      term_a  = ACC_W'(prod_a) <<< A_SHIFT;
      term_b  = ACC_W'(prod_b);
      term_y2 = ACC_W'(y2) <<< FRAC;
      sum     = term_a + term_b - term_y2;
   end

   generate
      if (RND == osc_pkg::RND_NEAREST) begin : g_round
         always_comb reduced = (sum + HALF) >>> FRAC;
      end else begin : g_trunc
         always_comb reduced = sum >>> FRAC;
      end
   endgenerate

   always_comb begin
      if (reduced > SAT_HI)      y_next = SAT_HI[DATA_W-1:0];
      else if (reduced < SAT_LO) y_next = SAT_LO[DATA_W-1:0];
      else                       y_next = reduced[DATA_W-1:0];
   end

endmodule

// File: rtl/impulse_resonator.sv
module impulse_resonator #(
   parameter int                  DATA_W = 16,
   parameter int                  A_FRAC = 14,
   parameter osc_pkg::rnd_mode_e  RND    = osc_pkg::RND_NEAREST
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     sample_en,
   input  logic signed [DATA_W-1:0] coef_a,
   input  logic signed [DATA_W-1:0] coef_b,
   output logic signed [DATA_W-1:0] sample_out,
   output logic                     sample_valid
);
   logic                     step;
   logic signed [DATA_W-1:0] h_y1;
   logic signed [DATA_W-1:0] h_y2;
   logic signed [DATA_W-1:0] h_x1;
   logic                     h_pending;
   logic signed [DATA_W-1:0] y_next;

   // A start in the same cycle wins over the strobe
   assign step = sample_en && !start;

   osc_history #(.DATA_W(DATA_W)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .advance (step),
      .y_new   (y_next),
      .y1      (h_y1),
      .y2      (h_y2),
      .x1      (h_x1),
      .pending (h_pending)
   );

   osc_mac #(.DATA_W(DATA_W), .A_FRAC(A_FRAC), .RND(RND)) u_mac (
      .coef_a (coef_a),
      .coef_b (coef_b),
      .y1     (h_y1),
      .y2     (h_y2),
      .x1     (h_x1),
      .y_next (y_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_out   <= '0;
         sample_valid <= 1'b0;
      end else begin
         sample_valid <= step;
         if (step) sample_out <= y_next;
      end
   end

   AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && h_pending) |-> (y_next == '0)); // R3

   AST_OUT_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> (sample_out == h_y1)); // R4

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(sample_out)); // R7

   AST_START_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!sample_valid && h_y1 == '0 && h_y2 == '0)); // R2

endmodule

// File: tb/impulse_resonator_tb.sv
module impulse_resonator_tb;
   logic               clk = 1'b0;
   logic               rst_n;
   logic               start;
   logic               sample_en;
   logic signed [15:0] coef_a;
   logic signed [15:0] coef_b;
   logic signed [15:0] sample_out;
   logic               sample_valid;

   always #2 clk = ~clk; // 250 MHz

   impulse_resonator u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .sample_en    (sample_en),
      .coef_a       (coef_a),
      .coef_b       (coef_b),
      .sample_out   (sample_out),
      .sample_valid (sample_valid)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   int    q_exp[$];
   string q_req[$];

   // Bench model state
   int m_y1, m_y2, m_x1;
   bit m_pend;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model_next(input int a, input int b);
      longint s;
      s = 2 * longint'(a) * longint'(m_y1) + longint'(b) * longint'(m_x1)
          - longint'(m_y2) * 32768;
      s = (s + 16384) >>> 15;
      if (s > 32767)  s = 32767;
      if (s < -32768) s = -32768;
      return int'(s);
   endfunction

   task automatic do_start();
      @(negedge clk);
      start = 1'b1;
      m_y1 = 0; m_y2 = 0; m_x1 = 0; m_pend = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Driver: one strobe, expected sample pushed to the scoreboard
   task automatic do_strobe(input string req);
      int e;
      @(negedge clk);
      sample_en = 1'b1;
      e = model_next(int'(coef_a), int'(coef_b));
      m_y2 = m_y1;
      m_y1 = e;
      m_x1 = m_pend ? 32767 : 0;
      m_pend = 1'b0;
      q_exp.push_back(e);
      q_req.push_back(req);
      @(negedge clk);
      sample_en = 1'b0;
   endtask

   // Monitor: compares each produced sample against the queue
   always @(negedge clk) begin
      if (rst_n && sample_valid) begin
         if (q_exp.size() == 0) begin
            check(1'b0, "R7 unexpected sample", int'(sample_out), 0);
         end else begin
            int    e;
            string r;
            e = q_exp.pop_front();
            r = q_req.pop_front();
            check(int'(sample_out) == e, r, int'(sample_out), e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; sample_en = 1'b0;
      coef_a = '0; coef_b = '0;
      m_y1 = 0; m_y2 = 0; m_x1 = 0; m_pend = 1'b0;
      repeat (3) @(negedge clk);
      check(sample_out == 0, "R1 reset sample_out", int'(sample_out), 0);
      check(sample_valid == 0, "R1 reset sample_valid", int'(sample_valid), 0);
      rst_n = 1'b1;

      // R9: no start, strobes yield zeros
      coef_a = 16'sd29491; coef_b = 16'sd14283;
      for (int i = 0; i < 3; i++) do_strobe("R9 no-start zero");

      // R3/R4: quarter-turn step, period-four pattern
      coef_a = 16'sd0; coef_b = 16'sd32767;
      do_start();
      do_strobe("R3 first sample zero");
      for (int i = 0; i < 8; i++) do_strobe("R4 quarter-turn");

      // R5: general angle, rounding on every sample
      coef_a = 16'sd29491; coef_b = 16'sd14283;
      do_start();
      for (int i = 0; i < 40; i++) do_strobe("R5 rounding general angle");

      // R7: hold between strobes
      begin
         logic signed [15:0] held;
         @(negedge clk);
         held = sample_out;
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(sample_out == held, "R7 hold", int'(sample_out), int'(held));
            check(sample_valid == 0, "R7 valid low", int'(sample_valid), 0);
         end
      end

      // R8: restart mid-run repeats the sequence
      do_start();
      for (int i = 0; i < 10; i++) do_strobe("R8 restart repeat");

      // R2: start with strobe in the same cycle, no sample
      @(negedge clk);
      start = 1'b1; sample_en = 1'b1;
      m_y1 = 0; m_y2 = 0; m_x1 = 0; m_pend = 1'b1;
      @(negedge clk);
      start = 1'b0; sample_en = 1'b0;
      check(sample_valid == 0, "R2 start overrides strobe", int'(sample_valid), 0);
      for (int i = 0; i < 4; i++) do_strobe("R2 after combined start");

      // R6: positive clip
      coef_a = 16'sd32767; coef_b = 16'sd32767;
      do_start();
      for (int i = 0; i < 6; i++) do_strobe("R6 positive clip");

      // R6: negative clip
      coef_a = -16'sd32768; coef_b = 16'sd32767;
      do_start();
      for (int i = 0; i < 6; i++) do_strobe("R6 negative clip");

      repeat (4) @(negedge clk);
      check(q_exp.size() == 0, "R7 missing samples", q_exp.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule